// File: doc/BRIEF.md
# ECC-Protected Byte-Writable Word Memory

This block is a single-port data memory organised as aligned 32-bit words. Every word is kept together with seven check bits of a single-error-correcting, double-error-detecting code: a Hamming code over the word, plus one overall parity bit. The block accepts one request per cycle through a valid/ready pair. A request is either a read or a write, and a write carries a four-bit byte mask.

The code covers the whole word, so a write that replaces only some of its bytes cannot produce new check bits from the incoming bytes alone. A write with all four mask bits set is encoded and stored in the cycle it is accepted. Any other mask starts an internal sequence that spends one extra cycle with ready low. In that cycle the block reads the old entry, corrects it, merges in the enabled bytes, re-encodes the result and writes it back. Because ready is low, no other request can reach the array between that read and that write.

Reads return the corrected word one cycle after they are accepted, together with a correctable flag and an uncorrectable flag. A fault-injection input flips chosen bits of the 39-bit entry as it is written, so that the correction paths can be exercised from outside the block.

Top module: `ecc_word_array`

## Requirements
- R1: After reset, req_ready is 1, and every word reads back as 0 with rd_ce=0 and rd_ue=0.
- R2: A write with req_be=4'b1111 is stored in the cycle it is accepted, and req_ready stays 1 in the following cycle.
- R3: A write with any other mask drives req_ready to 0 for exactly the one cycle after acceptance; a request presented in that cycle is not accepted.
- R4: After a masked write, byte lane i (bits 8i+7..8i) holds the new data where req_be[i]=1 and keeps its old value where req_be[i]=0.
- R5: A read accepted at a clock edge raises rd_valid for one cycle after that edge, and rd_data, rd_ce and rd_ue are valid in that same cycle; rd_ce and rd_ue stay 0 while rd_valid is 0.
- R6: If any single bit of the 39-bit stored entry is inverted, a read returns the original data with rd_ce=1 and rd_ue=0.
- R7: If any two distinct bits of the stored entry are inverted, a read reports rd_ue=1 and rd_ce=0.
- R8: A masked write over an entry with a single-bit error corrects the old word before merging, so the merged result reads back with no flags.
- R9: A masked write over an entry with a double-bit error is still performed: merge_ue is 1 for exactly the cycle after the busy cycle, the enabled bytes read back as written, and the entry carries fresh check bits.
- R10: inj_flip is sampled when a write is accepted, and each 1 bit inverts the matching bit of the entry written; inj_flip has no effect on reads.
- R11: A write with req_be=4'b0000 changes no data byte but rewrites the entry with fresh check bits, which clears a single-bit error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte mask for writes, bit i selects lane i |
| inj_flip | input | DATA_W+HB+1 | Bits to invert in the entry that is written |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Corrected read data |
| rd_ce | output | 1 | Read found and corrected a single-bit error |
| rd_ue | output | 1 | Read found an uncorrectable error |
| merge_ue | output | 1 | A masked write found an uncorrectable old word |

## Verification
The bench builds the block with ADDR_W=3 and the default 32-bit word, which gives 8 words and a 39-bit entry. That size makes it practical to apply all 16 byte masks to every address and to invert each of the 39 entry bits on its own. It also covers all 741 distinct bit pairs, so every syndrome path through correction and detection is exercised. The same small array allows the merge cases (clean, corrected and uncorrectable old word, and the empty mask) to be checked word by word against an arithmetic model.

// File: rtl/ecc_word_pkg.sv
package ecc_word_pkg;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_MERGE
    } seq_e;

    // Smallest number of Hamming check bits covering data_w data bits.
    function automatic int hamming_bits(input int data_w);
        int p;
        p = 1;
        while ((1 << p) < data_w + p + 1) p++;
        return p;
    endfunction

endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc #(
    parameter int DATA_W = 32,
    localparam int HB    = ecc_word_pkg::hamming_bits(DATA_W),
    localparam int CW    = DATA_W + HB + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW-1:0]     code_o
);
    localparam int NPOS = DATA_W + HB;

    logic [CW-1:0] spread;
    logic [HB-1:0] syn;
    logic [CW-1:0] code;

    // Data bits go to positions that are not powers of two.
    always_comb begin
        int di;
        di     = 0;
        spread = '0;
        for (int pos = 1; pos <= NPOS; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                spread[pos] = data_i[di];
                di++;
            end
        end
    end

    always_comb begin
        syn = '0;
        for (int pos = 1; pos <= NPOS; pos++) begin
            if (spread[pos]) syn ^= HB'(pos);
        end
    end

    always_comb begin
        code = spread;
        for (int k = 0; k < HB; k++) begin
            code[1 << k] = syn[k];
        end
        code[0] = ^code[CW-1:1];
    end

    assign code_o = code;

endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec #(
    parameter int DATA_W = 32,
    localparam int HB    = ecc_word_pkg::hamming_bits(DATA_W),
    localparam int CW    = DATA_W + HB + 1
) (
    input  logic [CW-1:0]     code_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ce_o,
    output logic              ue_o
);
    localparam int NPOS = DATA_W + HB;

    logic [HB-1:0] syn;
    logic          par;
    logic          in_range;
    logic [CW-1:0] fixed;

    always_comb begin
        syn = '0;
        for (int pos = 1; pos <= NPOS; pos++) begin
            if (code_i[pos]) syn ^= HB'(pos);
        end
    end

    assign par      = ^code_i;
    assign in_range = (int'(syn) <= NPOS);

    always_comb begin
        fixed = code_i;
        if (par && in_range) fixed[syn] = ~code_i[syn];
    end

    always_comb begin
        int di;
        di     = 0;
        data_o = '0;
        for (int pos = 1; pos <= NPOS; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                data_o[di] = fixed[pos];
                di++;
            end
        end
    end

    assign ce_o = par && in_range;
    assign ue_o = (!par && (syn != '0)) || (par && !in_range);

endmodule

// File: rtl/ecc_byte_merge.sv
module ecc_byte_merge #(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] new_i,
    input  logic [BYTES-1:0]  be_i,
    output logic [DATA_W-1:0] merged_o
);
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign merged_o[8*b +: 8] = be_i[b] ? new_i[8*b +: 8] : old_i[8*b +: 8];
    end
endmodule

// File: rtl/ecc_word_array.sv
module ecc_word_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int HB    = ecc_word_pkg::hamming_bits(DATA_W),
    localparam int CW    = DATA_W + HB + 1,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BYTES-1:0]  req_be,
    input  logic [CW-1:0]     inj_flip,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ce,
    output logic              rd_ue,
    output logic              merge_ue
);
    import ecc_word_pkg::*;

    typedef struct packed {
        seq_e              st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BYTES-1:0]  be;
        logic [CW-1:0]     flip;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
        logic              rd_ce;
        logic              rd_ue;
        logic              merge_ue;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [CW-1:0]     mem_q [DEPTH];

    logic              accept;
    logic              full_mask;
    logic [ADDR_W-1:0] rd_addr;
    logic [CW-1:0]     rd_code;
    logic [DATA_W-1:0] dec_data;
    logic              dec_ce;
    logic              dec_ue;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] enc_in;
    logic [CW-1:0]     enc_code;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [CW-1:0]     wr_code;

    // Only one array read per cycle: the merge owns it while busy.
    assign req_ready = (s_q.st == SEQ_IDLE);
    assign accept    = req_valid && req_ready;
    assign full_mask = &req_be;
    assign rd_addr   = (s_q.st == SEQ_MERGE) ? s_q.addr : req_addr;
    assign rd_code   = mem_q[rd_addr];

    ecc_secded_dec #(.DATA_W(DATA_W)) i_dec (
        .code_i (rd_code),
        .data_o (dec_data),
        .ce_o   (dec_ce),
        .ue_o   (dec_ue)
    );

    ecc_byte_merge #(.DATA_W(DATA_W)) i_merge (
        .old_i    (dec_data),
        .new_i    (s_q.wdata),
        .be_i     (s_q.be),
        .merged_o (merged)
    );

    // One encoder, shared by direct writes and merge write-back.
    assign enc_in = (s_q.st == SEQ_MERGE) ? merged : req_wdata;

    ecc_secded_enc #(.DATA_W(DATA_W)) i_enc (
        .data_i (enc_in),
        .code_o (enc_code)
    );

    always_comb begin
        wr_en   = 1'b0;
        wr_addr = req_addr;
        wr_code = enc_code ^ inj_flip;
        if (s_q.st == SEQ_MERGE) begin
            wr_en   = 1'b1;
            wr_addr = s_q.addr;
            wr_code = enc_code ^ s_q.flip;
        end else if (accept && req_write && full_mask) begin
            wr_en = 1'b1;
        end
    end

    always_comb begin
        s_d          = s_q;
        s_d.rd_valid = 1'b0;
        s_d.rd_ce    = 1'b0;
        s_d.rd_ue    = 1'b0;
        s_d.merge_ue = 1'b0;
        case (s_q.st)
            SEQ_IDLE: begin
                if (accept) begin
                    if (!req_write) begin
                        s_d.rd_valid = 1'b1;
                        s_d.rd_data  = dec_data;
                        s_d.rd_ce    = dec_ce;
                        s_d.rd_ue    = dec_ue;
                    end else if (!full_mask) begin
                        s_d.st    = SEQ_MERGE;
                        s_d.addr  = req_addr;
                        s_d.wdata = req_wdata;
                        s_d.be    = req_be;
                        s_d.flip  = inj_flip;
                    end
                end
            end
            SEQ_MERGE: begin
                s_d.st       = SEQ_IDLE;
                s_d.merge_ue = dec_ue;
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // The all-zero entry is a valid codeword for the all-zero word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_code;
        end
    end

    assign rd_valid = s_q.rd_valid;
    assign rd_data  = s_q.rd_data;
    assign rd_ce    = s_q.rd_ce;
    assign rd_ue    = s_q.rd_ue;
    assign merge_ue = s_q.merge_ue;

endmodule

// File: rtl/ecc_word_array_chk.sv
module ecc_word_array_chk #(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic [BYTES-1:0] req_be,
    input logic             rd_valid,
    input logic             rd_ce,
    input logic             rd_ue,
    input logic             merge_ue
);
    logic acc_rd, acc_full, acc_part;
    assign acc_rd   = req_valid && req_ready && !req_write;
    assign acc_full = req_valid && req_ready && req_write && (&req_be);
    assign acc_part = req_valid && req_ready && req_write && !(&req_be);

    AST_FULL_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_full |=> req_ready); // R2
    AST_PART_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_part |=> !req_ready); // R3
    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready); // R3
    AST_READ_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rd_valid); // R5
    AST_RESULT_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_rd)); // R5
    AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> !(rd_ce || rd_ue)); // R5
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ce && rd_ue)); // R7
    AST_MERGE_UE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        merge_ue |-> $past(!req_ready)); // R9

endmodule

bind ecc_word_array ecc_word_array_chk #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_be    (req_be),
    .rd_valid  (rd_valid),
    .rd_ce     (rd_ce),
    .rd_ue     (rd_ue),
    .merge_ue  (merge_ue)
);

// File: tb/test_ecc_word_array.sv
module test_ecc_word_array;
    localparam int AW = 3;
    localparam int NW = 1 << AW;
    localparam int EW = 39;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [3:0]    req_be = '0;
    logic [EW-1:0] inj_flip = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic          rd_ce;
    logic          rd_ue;
    logic          merge_ue;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;
    logic [31:0] model [NW];

    always #10 clk = ~clk;

    ecc_word_array #(.ADDR_W(AW), .DATA_W(32)) i_ecc_word_array (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .inj_flip(inj_flip), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_ce(rd_ce), .rd_ue(rd_ue), .merge_ue(merge_ue)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? n[8*i +: 8] : o[8*i +: 8];
        return r;
    endfunction

    function automatic logic [31:0] pat(input int a, input int n);
        return (32'h9E3779B9 * 32'(a + 1)) ^ (32'(n) * 32'h01000193) ^ 32'h5A0FC3E1;
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be,
                      input logic [EW-1:0] fl, output logic busy, output logic rdy_after,
                      output logic mue);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        req_be = be; inj_flip = fl;
        @(negedge clk);
        busy = !req_ready;
        req_valid = 1'b0; inj_flip = '0;
        if (busy) begin
            @(negedge clk);
            rdy_after = req_ready; mue = merge_ue;
        end else begin
            rdy_after = req_ready; mue = merge_ue;
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [EW-1:0] fl, output logic v,
                      output logic [31:0] d, output logic ce, output logic ue);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; inj_flip = fl;
        @(negedge clk);
        v = rd_valid; d = rd_data; ce = rd_ce; ue = rd_ue;
        req_valid = 1'b0; inj_flip = '0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    initial begin
        logic busy, rdy, mue, v, ce, ue;
        logic [31:0] d, nw;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 1);
        for (int a = 0; a < NW; a++) begin
            rd(AW'(a), '0, v, d, ce, ue);
            chk(v && d == 0 && !ce && !ue, "R1 reset word",
                {29'b0, v, ce, ue, d}, {29'b0, 3'b100, 32'h0});
            model[a] = 32'h0;
        end

        // R2 full writes
        for (int a = 0; a < NW; a++) begin
            wr(AW'(a), pat(a, 0), 4'hF, '0, busy, rdy, mue);
            chk(!busy && rdy, "R2 full write no stall", {busy, rdy}, 2'b01);
            model[a] = pat(a, 0);
            rd(AW'(a), '0, v, d, ce, ue);
            chk(v && d == model[a] && !ce && !ue, "R2 R5 full readback", d, model[a]);
        end

        // R3 R4 all masks on every word
        for (int a = 0; a < NW; a++) begin
            for (int m = 0; m < 16; m++) begin
                nw = pat(a, m + 1);
                wr(AW'(a), nw, 4'(m), '0, busy, rdy, mue);
                if (m == 15)
                    chk(!busy, "R2 full mask", busy, 0);
                else
                    chk(busy && rdy && !mue, "R3 one busy cycle", {busy, rdy, mue}, 3'b110);
                model[a] = mrg(model[a], nw, 4'(m));
                rd(AW'(a), '0, v, d, ce, ue);
                chk(v && d == model[a] && !ce && !ue, "R4 merged lanes", d, model[a]);
            end
        end

        // R3 request during busy cycle is not accepted
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd2; req_wdata = 32'hCAFEF00D;
        req_be = 4'b0010;
        @(negedge clk);
        chk(req_ready == 1'b0, "R3 ready low", 64'(req_ready), 0);
        req_write = 1'b0; req_addr = 3'd5;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rd_valid == 1'b0 && req_ready == 1'b1, "R3 stalled read not taken",
            {rd_valid, req_ready}, 2'b01);
        model[2] = mrg(model[2], 32'hCAFEF00D, 4'b0010);
        rd(3'd2, '0, v, d, ce, ue);
        chk(d == model[2], "R3 busy write result", d, model[2]);

        // R6 R10 every single flip
        for (int k = 0; k < EW; k++) begin
            wr(3'd1, pat(k, 7), 4'hF, EW'(1) << k, busy, rdy, mue);
            rd(3'd1, '0, v, d, ce, ue);
            chk(v && d == pat(k, 7) && ce && !ue, "R6 single flip corrected",
                {ce, ue, d}, {2'b10, pat(k, 7)});
        end

        // R7 every pair of flips
        for (int a = 0; a < EW - 1; a++) begin
            for (int b = a + 1; b < EW; b++) begin
                wr(3'd3, pat(a, b), 4'hF, (EW'(1) << a) | (EW'(1) << b), busy, rdy, mue);
                rd(3'd3, '0, v, d, ce, ue);
                chk(v && ue && !ce, "R7 double flip detected", {ce, ue}, 2'b01);
            end
        end

        // R10 flip ignored on reads
        wr(3'd4, 32'h13579BDF, 4'hF, '0, busy, rdy, mue);
        rd(3'd4, {EW{1'b1}}, v, d, ce, ue);
        chk(d == 32'h13579BDF && !ce && !ue, "R10 read ignores flip", d, 32'h13579BDF);
        rd(3'd4, '0, v, d, ce, ue);
        chk(d == 32'h13579BDF && !ce && !ue, "R10 entry untouched", d, 32'h13579BDF);

        // R8 merge over corrected word
        wr(3'd5, 32'h89ABCDEF, 4'hF, EW'(1) << 17, busy, rdy, mue);
        wr(3'd5, 32'h00001234, 4'b0011, '0, busy, rdy, mue);
        chk(busy && !mue, "R8 no merge_ue on single error", {busy, mue}, 2'b10);
        rd(3'd5, '0, v, d, ce, ue);
        chk(d == 32'h89AB1234 && !ce && !ue, "R8 corrected then merged", d, 32'h89AB1234);

        // R9 merge over uncorrectable word
        wr(3'd6, 32'h0F0F0F0F, 4'hF, (EW'(1) << 3) | (EW'(1) << 30), busy, rdy, mue);
        wr(3'd6, 32'h00AA00BB, 4'b0101, '0, busy, rdy, mue);
        chk(busy && mue, "R9 merge_ue raised", {busy, mue}, 2'b11);
        @(negedge clk);
        chk(merge_ue == 1'b0, "R9 merge_ue one cycle", 64'(merge_ue), 0);
        rd(3'd6, '0, v, d, ce, ue);
        chk(!ce && !ue && (d & 32'h00FF00FF) == 32'h00AA00BB, "R9 write performed",
            {ce, ue, d & 32'h00FF00FF}, {2'b00, 32'h00AA00BB});

        // R11 empty mask scrubs
        wr(3'd7, 32'hDEADBEEF, 4'hF, EW'(1) << 38, busy, rdy, mue);
        wr(3'd7, 32'hFFFFFFFF, 4'b0000, '0, busy, rdy, mue);
        chk(busy, "R11 empty mask takes merge path", busy, 1);
        rd(3'd7, '0, v, d, ce, ue);
        chk(d == 32'hDEADBEEF && !ce && !ue, "R11 scrubbed", {ce, ue, d}, {2'b00, 32'hDEADBEEF});

        done = 1;
        summary();
    end
endmodule